// File: doc/BRIEF.md
# Two-Bit Condition Code Unit with Mask-Selected Branching

This block condenses the outcome of an arithmetic step into a single 2-bit condition code (CC). The meaning of the code depends on the operation that wrote it. Three operations are supported: a two's-complement add, an unsigned ("logical") add and a compare. Each takes two N-bit operands. A write enable decides whether the operation's outcome replaces the stored code.

Branch resolution does not decode flags. A branch supplies a 4-bit mask that holds one bit per possible CC value. The branch is taken when the bit standing for the stored CC value is set. Mask bits are counted from the left: the most significant bit stands for CC 0 and the least significant bit stands for CC 3. Any set of the four outcomes can therefore be tested with a single mask. For example, `1010` means "result zero or positive" after a signed add, and `1101` means "not high" after a compare.

Branch-target arithmetic and the rest of the datapath sit outside this block.

Top module: `cc_branch_unit`

## Requirements
- R1: While reset is asserted, and after it is released, the stored CC is 0 until the first accepted update.
- R2: Signed add (op_sel = 0) without overflow stores CC 0 when the WIDTH-bit sum is zero, CC 1 when the sum is negative and CC 2 when the sum is positive.
- R3: Signed add with two's-complement overflow stores CC 3. This takes priority over the zero and sign cases, including a wrapped sum of zero.
- R4: Logical add (op_sel = 1) stores {carry_out, result_nonzero}: 0 for a zero result without carry, 1 for a nonzero result without carry, 2 for a zero result with carry, 3 for a nonzero result with carry.
- R5: Compare (op_sel = 2) treats both operands as signed. It stores 0 when they are equal, 1 when op_a is lower and 2 when op_a is higher. It never stores 3.
- R6: The stored CC does not change when cc_we is low, or when op_sel = 3 (reserved), whatever the operands are.
- R7: br_taken equals br_mask[3 - cc], so mask bit 3 selects CC 0 and mask bit 0 selects CC 3.
- R8: Mask 4'b1111 always gives br_taken = 1, and mask 4'b0000 always gives br_taken = 0.
- R9: br_taken is evaluated against the registered CC. An update presented in a cycle affects br_taken only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| op_sel | input | 2 | 0 signed add, 1 logical add, 2 compare, 3 reserved |
| cc_we | input | 1 | Store the operation's CC at the next edge |
| br_mask | input | 4 | Branch mask, bit 3 selects CC 0 |
| br_taken | output | 1 | Branch decision against the stored CC |
| cc_out | output | 2 | Stored condition code |

## Verification
A CC update is due one rising edge after it is presented with cc_we high. br_taken, however, follows br_mask within the same cycle, combinationally from the stored code. The driver holds each stimulus from a falling edge to the next falling edge. After every rising edge it queues the expected code and decision, and the monitor compares them 1 ns after that edge. Before the edge, the driver also samples br_taken 1 ns after applying new inputs, to confirm that the decision still reflects the old code.

// File: rtl/cc_pkg.sv
package cc_pkg;
   typedef enum logic [1:0] {
      OP_SADD = 2'd0,
      OP_LADD = 2'd1,
      OP_CMP  = 2'd2,
      OP_RSVD = 2'd3
   } cc_op_e;

   localparam int CC_W   = 2;
   localparam int MASK_W = 1 << CC_W;
endpackage

// File: rtl/cc_gen.sv
module cc_gen
   import cc_pkg::*;
#(
   parameter int WIDTH      = 32,
   parameter bit CMP_SIGNED = 1'b1
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [1:0]       op,
   output logic [CC_W-1:0]  cc,
   output logic             legal
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH:0]   wide_sum;
   logic [WIDTH-1:0] sum;
   logic             carry, zero, ovf, eq, lt;

   assign wide_sum = {1'b0, a} + {1'b0, b};
   assign sum      = wide_sum[MSB:0];
   assign carry    = wide_sum[WIDTH];
   assign zero     = (sum == '0);
   assign ovf      = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
   assign eq       = (a == b);

   generate
      if (CMP_SIGNED) begin : g_cmp_s
         assign lt = ($signed(a) < $signed(b));
      end else begin : g_cmp_u
         assign lt = (a < b);
      end
   endgenerate

   always_comb begin
      cc    = 2'd0;
      legal = 1'b1;
      case (op)
         OP_SADD: begin
            if (ovf)           cc = 2'd3;
            else if (zero)     cc = 2'd0;
            else if (sum[MSB]) cc = 2'd1;
            else               cc = 2'd2;
         end
         OP_LADD: cc = {carry, ~zero};
         OP_CMP: begin
            if (eq)      cc = 2'd0;
            else if (lt) cc = 2'd1;
            else         cc = 2'd2;
         end
         default: legal = 1'b0;
      endcase
   end
endmodule

// File: rtl/cc_reg.sv
module cc_reg
   import cc_pkg::*;
#(
   parameter logic [CC_W-1:0] RESET_CC = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [CC_W-1:0] cc_d,
   output logic [CC_W-1:0] cc_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cc_q <= RESET_CC;
      else if (load) cc_q <= cc_d;
   end
endmodule

// File: rtl/cc_mask_match.sv
module cc_mask_match
   import cc_pkg::*;
#(
   parameter int MATCH_STYLE = 0
) (
   input  logic [CC_W-1:0]   cc,
   input  logic [MASK_W-1:0] mask,
   output logic              hit
);
   localparam logic [CC_W-1:0] TOP = CC_W'(MASK_W - 1);

   generate
      if (MATCH_STYLE == 0) begin : g_mux
         logic [CC_W-1:0] idx;
         assign idx = TOP - cc;
         assign hit = mask[idx];
      end else begin : g_onehot
         logic [MASK_W-1:0] sel;
         assign sel = {1'b1, {(MASK_W-1){1'b0}}} >> cc;
         assign hit = |(sel & mask);
      end
   endgenerate
endmodule

// File: rtl/cc_branch_unit.sv
module cc_branch_unit
   import cc_pkg::*;
#(
   parameter int WIDTH       = 32,
   parameter bit CMP_SIGNED  = 1'b1,
   parameter int MATCH_STYLE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic [1:0]       op_sel,
   input  logic             cc_we,
   input  logic [3:0]       br_mask,
   output logic             br_taken,
   output logic [1:0]       cc_out
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("cc_branch_unit: WIDTH must be at least 2");
      end
      if (MATCH_STYLE != 0 && MATCH_STYLE != 1) begin : g_bad_style
         $error("cc_branch_unit: MATCH_STYLE must be 0 or 1");
      end
   endgenerate

   logic [CC_W-1:0] cc_next;
   logic            op_legal;

   cc_gen #(.WIDTH(WIDTH), .CMP_SIGNED(CMP_SIGNED)) u_gen (
      .a(op_a), .b(op_b), .op(op_sel), .cc(cc_next), .legal(op_legal)
   );

   cc_reg #(.RESET_CC(2'd0)) u_reg (
      .clk(clk), .rst_n(rst_n), .load(cc_we && op_legal),
      .cc_d(cc_next), .cc_q(cc_out)
   );

   cc_mask_match #(.MATCH_STYLE(MATCH_STYLE)) u_match (
      .cc(cc_out), .mask(br_mask), .hit(br_taken)
   );
endmodule

// File: rtl/cc_branch_chk.sv
module cc_branch_chk #(
   parameter int WIDTH = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] op_a,
   input logic [WIDTH-1:0] op_b,
   input logic [1:0]       op_sel,
   input logic             cc_we,
   input logic [3:0]       br_mask,
   input logic             br_taken,
   input logic [1:0]       cc_out
);
   logic [WIDTH-1:0] chk_sum;
   logic             chk_ovf;
   assign chk_sum = op_a + op_b;
   assign chk_ovf = (op_a[WIDTH-1] == op_b[WIDTH-1]) && (chk_sum[WIDTH-1] != op_a[WIDTH-1]);

   AST_RESET_CC: assert property (@(posedge clk) !rst_n |-> cc_out == 2'd0); // R1
   AST_SADD_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      (cc_we && op_sel == 2'd0 && chk_ovf) |=> cc_out == 2'd3); // R3
   AST_CMP_EQ: assert property (@(posedge clk) disable iff (!rst_n)
      (cc_we && op_sel == 2'd2 && op_a == op_b) |=> cc_out == 2'd0); // R5
   AST_CMP_NO3: assert property (@(posedge clk) disable iff (!rst_n)
      (cc_we && op_sel == 2'd2) |=> cc_out != 2'd3); // R5
   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!cc_we || op_sel == 2'd3) |=> $stable(cc_out)); // R6
   AST_MASK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      br_mask == 4'hF |-> br_taken); // R8
   AST_MASK_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      br_mask == 4'h0 |-> !br_taken); // R8
endmodule

bind cc_branch_unit cc_branch_chk #(.WIDTH(WIDTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
   .cc_we(cc_we), .br_mask(br_mask), .br_taken(br_taken), .cc_out(cc_out)
);

// File: tb/sim_cc_branch_unit.sv
`timescale 1ns/1ps
module sim_cc_branch_unit;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] op_a = '0, op_b = '0;
   logic [1:0]   op_sel = 2'd0;
   logic         cc_we = 1'b0;
   logic [3:0]   br_mask = 4'h0;
   logic         br_taken;
   logic [1:0]   cc_out;

   typedef struct {
      logic [1:0] cc;
      logic       taken;
      string      tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_cmp = 0, n_bad = 0;
   logic [1:0] model_cc = 2'd0;
   bit   done = 1'b0;

   always #5 clk = ~clk;

   cc_branch_unit #(.WIDTH(W)) u0 (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
      .cc_we(cc_we), .br_mask(br_mask), .br_taken(br_taken), .cc_out(cc_out)
   );

   function automatic logic [1:0] ref_cc(logic [W-1:0] a, logic [W-1:0] b,
                                         logic [1:0] op, logic [1:0] cur);
      logic [W:0] s;
      logic       v;
      s = {1'b0, a} + {1'b0, b};
      v = (a[W-1] == b[W-1]) && (s[W-1] != a[W-1]);
      case (op)
         2'd0: begin
            if (v) return 2'd3;
            if (s[W-1:0] == 0) return 2'd0;
            return s[W-1] ? 2'd1 : 2'd2;
         end
         2'd1: return {s[W], s[W-1:0] != 0};
         2'd2: begin
            if (a == b) return 2'd0;
            return ($signed(a) < $signed(b)) ? 2'd1 : 2'd2;
         end
         default: return cur;
      endcase
   endfunction

   task automatic check(string tag, logic [1:0] cc_a, logic [1:0] cc_e,
                        logic tk_a, logic tk_e);
      n_cmp++;
      if (cc_a !== cc_e || tk_a !== tk_e) begin
         n_bad++;
         $display("FAIL %s: cc=%0d taken=%0b expected cc=%0d taken=%0b",
                  tag, cc_a, tk_a, cc_e, tk_e);
      end
   endtask

   // driver: apply at negedge, check pre-edge decision, queue post-edge result
   task automatic drive(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] op,
                        logic we, logic [3:0] m, string tag);
      exp_t e;
      @(negedge clk);
      op_a = a; op_b = b; op_sel = op; cc_we = we; br_mask = m;
      #1;
      check({tag, " R9 pre-edge"}, cc_out, model_cc, br_taken, m[3 - model_cc]);
      if (we) model_cc = ref_cc(a, b, op, model_cc);
      e.cc = model_cc; e.taken = m[3 - model_cc]; e.tag = tag;
      @(posedge clk);
      exp_q.push_back(e);
   endtask

   // monitor
   initial begin
      forever begin
         @(posedge clk);
         #1;
         while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.tag, cc_out, e.cc, br_taken, e.taken);
         end
      end
   end

   initial begin
      #100000;
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: run did not finish (actual hung, expected done)");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      br_mask = 4'b1000;
      #22;
      check("R1 in reset", cc_out, 2'd0, br_taken, 1'b1);
      @(negedge clk); rst_n = 1'b1;
      #1;
      check("R1 after reset", cc_out, 2'd0, br_taken, 1'b1);

      // R2 signed add
      drive(8'd3,   8'd4,   2'd0, 1, 4'b1010, "R2 sadd positive mask1010");
      drive(8'd5,   8'hF9,  2'd0, 1, 4'b0100, "R2 sadd negative");
      drive(8'd7,   8'hF9,  2'd0, 1, 4'b1010, "R2 sadd zero ge");
      // R3 overflow priority
      drive(8'd100, 8'd100, 2'd0, 1, 4'b0001, "R3 sadd pos overflow");
      drive(8'h80,  8'h80,  2'd0, 1, 4'b1000, "R3 sadd overflow wraps to zero");
      drive(8'h80,  8'hFF,  2'd0, 1, 4'b0110, "R3 sadd neg overflow");
      // R4 logical add
      drive(8'd0,   8'd0,   2'd1, 1, 4'b1000, "R4 ladd zero nocarry");
      drive(8'd1,   8'd2,   2'd1, 1, 4'b0100, "R4 ladd nonzero nocarry");
      drive(8'h80,  8'h80,  2'd1, 1, 4'b0010, "R4 ladd zero carry");
      drive(8'hFF,  8'h02,  2'd1, 1, 4'b0001, "R4 ladd nonzero carry");
      // R5 compare, mask 1101 = not high
      drive(8'd9,   8'd9,   2'd2, 1, 4'b1101, "R5 cmp equal");
      drive(8'hFF,  8'd1,   2'd2, 1, 4'b1101, "R5 cmp signed low");
      drive(8'd1,   8'hFF,  2'd2, 1, 4'b1101, "R5 cmp signed high not-high");
      drive(8'h7F,  8'h80,  2'd2, 1, 4'b0010, "R5 cmp high extreme");
      // R6 hold
      drive(8'd0,   8'd0,   2'd1, 0, 4'b0010, "R6 we low ladd");
      drive(8'h80,  8'h80,  2'd0, 0, 4'b0010, "R6 we low sadd");
      drive(8'hFF,  8'h02,  2'd3, 1, 4'b0010, "R6 reserved op");
      // R7 single-bit masks against each CC value
      for (int c = 0; c < 4; c++) begin
         drive(8'h80, 8'h80, 2'd1, 1, 4'b0001 << c, "R7 single bit mask cc2");
      end
      drive(8'd1,   8'hFF,  2'd0, 1, 4'b1000, "R7 cc0 msb mask");
      // R8 always / never
      drive(8'd100, 8'd100, 2'd0, 1, 4'hF, "R8 mask all cc3");
      drive(8'd100, 8'd100, 2'd0, 1, 4'h0, "R8 mask none cc3");
      drive(8'd0,   8'd0,   2'd0, 1, 4'hF, "R8 mask all cc0");
      drive(8'd0,   8'd0,   2'd0, 1, 4'h0, "R8 mask none cc0");
      // R9 mask change on held CC
      drive(8'd0,   8'd0,   2'd0, 0, 4'b0111, "R9 held cc mask change");

      @(negedge clk);
      cc_we = 1'b0;
      @(posedge clk); #2;
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule